// File: doc/BRIEF.md
# Fused Micro-op Reservation Station

This block is a small scheduler queue. One allocation puts one fused micro-op into one entry. The micro-op is one of three kinds: a plain single operation, a fused store, or a fused load-and-operate. Each entry keeps three source tags, and each tag has a ready bit. Every cycle, the ready bits are updated against a result-tag broadcast that carries a valid bit. The block does not split a fused micro-op when it is allocated. It splits it when it dispatches, sending its two parts to up to three issue ports: address generation, store data and ALU.

A fused store sends its address part and its data part independently. Each part goes as soon as its own sources are ready, so the two may leave in any order or in the same cycle. A fused load-and-operate is serial. The load part goes to address generation first. The operate part becomes eligible for the ALU only after the load part has been reported complete. Completion reports carry an entry index and a part identifier. The block offers an entry for retirement once every part of that entry has completed. After the retirement is acknowledged, the entry becomes free again in the next cycle. A flush empties the whole queue in one cycle.

Top module: `fuse_rs_top`

## Requirements
- R1: After reset the queue is empty: `full`=0, `alloc_idx`=0, and `agu_valid`, `sd_valid`, `alu_valid` and `retire_valid` are all 0.
- R2: An allocation request with `full`=0 writes the lowest-numbered free entry, and `alloc_idx` shows that entry. `full` is 1 exactly when every entry is occupied. An allocation request made while `full`=1 is dropped and changes no entry.
- R3: A source becomes ready when `bc_valid` is 1 and `bc_tag` equals its stored tag. A tag that matches in the same cycle as its allocation is captured as ready.
- R4: Kind code 1 is a fused store. Its address part (part 0) is offered on the address-generation port once sources 0 and 1 are ready, whatever the state of source 2.
- R5: The data part (part 1) of a store is offered on the store-data port once source 2 is ready. It does not depend on the address part, so it may be offered before it.
- R6: Kind code 2 is a fused load-and-operate. Its load part (part 0) is offered on the address-generation port once sources 0 and 1 are ready. Its operate part (part 1) is offered on the ALU port only when source 2 is ready and part 0 was reported complete in an earlier cycle.
- R7: Kind code 0 is a plain operation. It is offered on the ALU port as part 0 once sources 0 and 1 are ready. It has no second part.
- R8: Each port offers at most one part per cycle. Among the entries that are eligible for a port, the one allocated earliest is offered.
- R9: Each part is offered exactly once. The cycle after a part is offered, it is not offered again.
- R10: `retire_valid` is 1 only for an entry whose every part has completed. `retire_idx` names the earliest-allocated such entry.
- R11: When `retire_ack` is 1 while `retire_valid` is 1, the entry named by `retire_idx` is free in the next cycle.
- R12: `flush` empties every entry in one cycle. It takes precedence over an allocation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Empty the whole queue |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 0 plain, 1 store, 2 load-and-operate |
| alloc_tag0 | input | TAG_W | Source 0 tag (base) |
| alloc_tag1 | input | TAG_W | Source 1 tag (index) |
| alloc_tag2 | input | TAG_W | Source 2 tag (store data or operate operand) |
| alloc_rdy | input | 3 | Ready at allocation, bit s for source s |
| alloc_idx | output | IDX_W | Entry that an allocation this cycle would fill |
| full | output | 1 | No free entry |
| bc_valid | input | 1 | Result-tag broadcast valid |
| bc_tag | input | TAG_W | Broadcast result tag |
| agu_valid | output | 1 | Address-generation port offers a part |
| agu_idx | output | IDX_W | Entry of that part (always part 0) |
| sd_valid | output | 1 | Store-data port offers a part |
| sd_idx | output | IDX_W | Entry of that part (always part 1) |
| alu_valid | output | 1 | ALU port offers a part |
| alu_idx | output | IDX_W | Entry of that part |
| alu_part | output | 1 | 0 plain operation, 1 operate part |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | IDX_W | Entry that completed a part |
| cmp_part | input | 1 | Part that completed |
| retire_valid | output | 1 | An entry may retire |
| retire_idx | output | IDX_W | Entry offered for retirement |
| retire_ack | input | 1 | Retirement accepted; free the entry |

## Verification
The hardest case to reach is several eligible entries competing for one port while their ages differ from their index order. That case only arises after entries have been freed and reallocated out of order, and the operate parts of load-and-operate entries can only compete once completions have come back for their load parts. The random phase uses a small tag alphabet, so broadcasts wake entries often. It returns completions for randomly chosen outstanding parts and acknowledges retirements at random, which keeps the queue churning so that entry ages interleave. A bench model holds a sequence number for each entry and checks every port against the oldest-eligible rule in every cycle. Directed cases first cover these situations:
- allocation-time wakeup;
- store data leaving before its address;
- the serial load-then-operate order;
- allocation against a full queue;
- a flush that collides with an allocation.

// File: rtl/fuse_rs_pkg.sv
// Shared types for the fused micro-op reservation station.
package fuse_rs_pkg;
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_STORE = 2'd1,
        KIND_LDOP  = 2'd2
    } kind_t;

    localparam int NSRC = 3;
endpackage

// File: rtl/fuse_rs_entry.sv
// One queue slot: kind, three source tags with ready bits, and
// dispatched/completed flags for its two parts.
// Assumes the top gates completions to valid slots and never allocates
// into a busy slot. Flush has priority over everything else.
module fuse_rs_entry
    import fuse_rs_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        alloc_en,
    input  kind_t                       alloc_kind,
    input  logic [NSRC-1:0][TAG_W-1:0]  alloc_tags,
    input  logic [NSRC-1:0]             alloc_rdy,
    input  logic                        bc_valid,
    input  logic [TAG_W-1:0]            bc_tag,
    input  logic                        gnt_agu,
    input  logic                        gnt_sd,
    input  logic                        gnt_alu,
    input  logic                        cmp_first,
    input  logic                        cmp_second,
    input  logic                        free_en,
    output logic                        busy,
    output logic                        req_agu,
    output logic                        req_sd,
    output logic                        req_alu,
    output logic                        ret_rdy
);
    kind_t                       kind_q;
    logic [NSRC-1:0][TAG_W-1:0]  tag_q;
    logic [NSRC-1:0]             rdy_q;
    logic                        disp_a, disp_b, done_a, done_b;
    logic [NSRC-1:0]             hit_new, hit_cur;

    // Tag comparators for incoming and stored tags against the broadcast.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            hit_new[s] = bc_valid && (alloc_tags[s] == bc_tag);
            hit_cur[s] = bc_valid && (tag_q[s] == bc_tag);
        end
    end

    // Slot state update: allocate, wake up, mark dispatch and completion, free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            kind_q <= KIND_PLAIN;
            tag_q  <= '0;
            rdy_q  <= '0;
            disp_a <= 1'b0;
            disp_b <= 1'b0;
            done_a <= 1'b0;
            done_b <= 1'b0;
        end else if (flush) begin
            busy <= 1'b0;
        end else if (alloc_en) begin
            busy   <= 1'b1;
            kind_q <= alloc_kind;
            tag_q  <= alloc_tags;
            rdy_q  <= alloc_rdy | hit_new;
            disp_a <= 1'b0;
            done_a <= 1'b0;
            disp_b <= (alloc_kind == KIND_PLAIN);
            done_b <= (alloc_kind == KIND_PLAIN);
        end else begin
            if (free_en)
                busy <= 1'b0;
            rdy_q <= rdy_q | hit_cur;
            if (gnt_agu || (gnt_alu && kind_q == KIND_PLAIN))
                disp_a <= 1'b1;
            if (gnt_sd || (gnt_alu && kind_q == KIND_LDOP))
                disp_b <= 1'b1;
            if (cmp_first)
                done_a <= 1'b1;
            if (cmp_second)
                done_b <= 1'b1;
        end
    end

    // Eligibility of each part for its port, and retire readiness.
    always_comb begin
        req_agu = busy && (kind_q != KIND_PLAIN) && !disp_a && rdy_q[0] && rdy_q[1];
        req_sd  = busy && (kind_q == KIND_STORE) && !disp_b && rdy_q[2];
        req_alu = busy && (((kind_q == KIND_PLAIN) && !disp_a && rdy_q[0] && rdy_q[1]) ||
                           ((kind_q == KIND_LDOP) && done_a && !disp_b && rdy_q[2]));
        ret_rdy = busy && done_a && done_b;
    end
endmodule

// File: rtl/fuse_rs_age.sv
// Allocation-order matrix: bit [i][j] set means slot i was allocated
// before slot j. Assumes alloc_en never targets a busy slot; stale rows
// of free slots are rewritten on their next allocation.
module fuse_rs_age #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic [IDX_W-1:0]       alloc_idx,
    output logic [N-1:0][N-1:0]    older
);
    // Newly allocated slot becomes younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < N; j++) begin
                older[alloc_idx][j] <= 1'b0;
                older[j][alloc_idx] <= (j != int'(alloc_idx));
            end
        end
    end
endmodule

// File: rtl/fuse_rs_pick.sv
// Oldest-request selector: grants the requester that no other requester
// predates. Assumes an age matrix with a zero diagonal and a strict order.
module fuse_rs_pick #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]           req,
    input  logic [N-1:0][N-1:0]    older,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    // Scan every requester for an older competing requester.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            logic win;
            win = req[i];
            for (int j = 0; j < N; j++)
                if (req[j] && older[j][i])
                    win = 1'b0;
            if (win) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fuse_rs_top.sv
// Fused micro-op reservation station. Holds ENTRIES fused micro-ops and
// splits each into its parts at dispatch. Ports always accept what they
// are offered. Completions must name a part that was dispatched.
module fuse_rs_top
    import fuse_rs_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 6,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [TAG_W-1:0]  alloc_tag0,
    input  logic [TAG_W-1:0]  alloc_tag1,
    input  logic [TAG_W-1:0]  alloc_tag2,
    input  logic [2:0]        alloc_rdy,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    output logic              agu_valid,
    output logic [IDX_W-1:0]  agu_idx,
    output logic              sd_valid,
    output logic [IDX_W-1:0]  sd_idx,
    output logic              alu_valid,
    output logic [IDX_W-1:0]  alu_idx,
    output logic              alu_part,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              cmp_part,
    output logic              retire_valid,
    output logic [IDX_W-1:0]  retire_idx,
    input  logic              retire_ack
);
    logic [ENTRIES-1:0]          busy, req_agu, req_sd, req_alu, ret_rdy;
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    logic [NSRC-1:0][TAG_W-1:0]  tags_in;
    logic                        alloc_go;
    logic [ENTRIES-1:0]          alu_is_op;

    assign tags_in  = {alloc_tag2, alloc_tag1, alloc_tag0};
    assign alloc_go = alloc_valid && !full && !flush;

    // Lowest free slot and the full flag.
    always_comb begin
        full      = &busy;
        alloc_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!busy[i])
                alloc_idx = IDX_W'(i);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        fuse_rs_entry #(.TAG_W(TAG_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .alloc_en   (alloc_go && (alloc_idx == IDX_W'(g))),
            .alloc_kind (kind_t'(alloc_kind)),
            .alloc_tags (tags_in),
            .alloc_rdy  (alloc_rdy),
            .bc_valid   (bc_valid),
            .bc_tag     (bc_tag),
            .gnt_agu    (agu_valid && (agu_idx == IDX_W'(g))),
            .gnt_sd     (sd_valid && (sd_idx == IDX_W'(g))),
            .gnt_alu    (alu_valid && (alu_idx == IDX_W'(g))),
            .cmp_first  (cmp_valid && (cmp_idx == IDX_W'(g)) && !cmp_part),
            .cmp_second (cmp_valid && (cmp_idx == IDX_W'(g)) && cmp_part),
            .free_en    (retire_valid && retire_ack && (retire_idx == IDX_W'(g))),
            .busy       (busy[g]),
            .req_agu    (req_agu[g]),
            .req_sd     (req_sd[g]),
            .req_alu    (req_alu[g]),
            .ret_rdy    (ret_rdy[g])
        );
        // The operate part of a load-and-operate needs done_a, which a plain op never waits for.
        assign alu_is_op[g] = req_alu[g] && !req_agu[g] && (g_slot[g].u_entry.kind_q == KIND_LDOP);
    end

    fuse_rs_age #(.N(ENTRIES), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_go),
        .alloc_idx (alloc_idx),
        .older     (older)
    );

    fuse_rs_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_agu (
        .req(req_agu), .older(older), .any(agu_valid), .idx(agu_idx));
    fuse_rs_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_sd (
        .req(req_sd), .older(older), .any(sd_valid), .idx(sd_idx));
    fuse_rs_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_alu (
        .req(req_alu), .older(older), .any(alu_valid), .idx(alu_idx));
    fuse_rs_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_ret (
        .req(ret_rdy), .older(older), .any(retire_valid), .idx(retire_idx));

    // Part identifier of the ALU winner.
    assign alu_part = alu_is_op[alu_idx];
endmodule

// File: rtl/fuse_rs_chk.sv
// Port-level assertions for fuse_rs_top, bound to every instance.
module fuse_rs_chk #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 6,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [TAG_W-1:0] bc_tag,
    input logic             full,
    input logic             agu_valid,
    input logic [IDX_W-1:0] agu_idx,
    input logic             sd_valid,
    input logic [IDX_W-1:0] sd_idx,
    input logic             alu_valid,
    input logic [IDX_W-1:0] alu_idx,
    input logic             alu_part,
    input logic             retire_valid,
    input logic [IDX_W-1:0] retire_idx,
    input logic             retire_ack
);
    logic unused_tag;
    assign unused_tag = ^bc_tag;

    AST_NO_REPEAT_AGU: assert property (@(posedge clk) disable iff (!rst_n)
        agu_valid |=> !(agu_valid && agu_idx == $past(agu_idx))); // R9
    AST_NO_REPEAT_SD: assert property (@(posedge clk) disable iff (!rst_n)
        sd_valid |=> !(sd_valid && sd_idx == $past(sd_idx))); // R9
    AST_NO_REPEAT_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid |=> !(alu_valid && alu_idx == $past(alu_idx) && alu_part == $past(alu_part))); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!full && !agu_valid && !sd_valid && !alu_valid && !retire_valid)); // R12
    AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_ack) |=> !(retire_valid && retire_idx == $past(retire_idx))); // R11
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush && !retire_ack) |=> full); // R2
endmodule

bind fuse_rs_top fuse_rs_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/fuse_rs_top_bench.sv
module fuse_rs_top_bench;
    localparam int N  = 4;
    localparam int TW = 6;
    localparam int IW = 2;

    logic clk = 1'b0, rst_n = 1'b0, flush;
    logic alloc_valid; logic [1:0] alloc_kind;
    logic [TW-1:0] alloc_tag0, alloc_tag1, alloc_tag2; logic [2:0] alloc_rdy;
    logic [IW-1:0] alloc_idx; logic full;
    logic bc_valid; logic [TW-1:0] bc_tag;
    logic agu_valid, sd_valid, alu_valid, alu_part, retire_valid;
    logic [IW-1:0] agu_idx, sd_idx, alu_idx, retire_idx;
    logic cmp_valid, cmp_part, retire_ack; logic [IW-1:0] cmp_idx;

    always #4 clk = ~clk;

    fuse_rs_top #(.ENTRIES(N), .TAG_W(TW)) u_fuse_rs_top (.*);

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // Bench model of the queue
    bit mv[N]; int mk[N]; int mt[N][3]; bit mr[N][3];
    bit mda[N], mdb[N], mca[N], mcb[N]; int mseq[N]; int seqc = 0;
    bit e_full; int e_aidx;
    int e_agu, e_sd, e_alu, e_alup, e_ret;   // -1 when nothing offered

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    function automatic int oldest(input bit [N-1:0] r);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && (best < 0 || mseq[i] < mseq[best])) best = i;
        return best;
    endfunction

    task automatic compute_exp();
        bit [N-1:0] ra, rs, rl, rr;
        for (int i = 0; i < N; i++) begin
            ra[i] = mv[i] && mk[i] != 0 && !mda[i] && mr[i][0] && mr[i][1];
            rs[i] = mv[i] && mk[i] == 1 && !mdb[i] && mr[i][2];
            rl[i] = mv[i] && ((mk[i] == 0 && !mda[i] && mr[i][0] && mr[i][1]) ||
                              (mk[i] == 2 && mca[i] && !mdb[i] && mr[i][2]));
            rr[i] = mv[i] && mca[i] && mcb[i];
        end
        e_agu = oldest(ra); e_sd = oldest(rs); e_alu = oldest(rl); e_ret = oldest(rr);
        e_alup = (e_alu >= 0 && mk[e_alu] == 2) ? 1 : 0;
        e_full = 1; e_aidx = 0;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) begin e_full = 0; e_aidx = i; end
    endtask

    task automatic check_outputs();
        check("R2 full", full, e_full);
        if (!e_full) check("R2 alloc_idx", alloc_idx, e_aidx);
        check("R4 R6 R8 agu_valid", agu_valid, e_agu >= 0);
        if (e_agu >= 0) check("R8 agu_idx", agu_idx, e_agu);
        check("R5 R8 sd_valid", sd_valid, e_sd >= 0);
        if (e_sd >= 0) check("R8 sd_idx", sd_idx, e_sd);
        check("R6 R7 R8 alu_valid", alu_valid, e_alu >= 0);
        if (e_alu >= 0) begin
            check("R8 alu_idx", alu_idx, e_alu);
            check("R6 R7 alu_part", alu_part, e_alup);
        end
        check("R10 retire_valid", retire_valid, e_ret >= 0);
        if (e_ret >= 0) check("R10 retire_idx", retire_idx, e_ret);
    endtask

    task automatic update_model();
        if (flush) begin
            for (int i = 0; i < N; i++) mv[i] = 0;
            return;
        end
        if (e_agu >= 0) mda[e_agu] = 1;
        if (e_sd >= 0) mdb[e_sd] = 1;
        if (e_alu >= 0) begin if (e_alup) mdb[e_alu] = 1; else mda[e_alu] = 1; end
        if (cmp_valid && mv[cmp_idx]) begin
            if (cmp_part) mcb[cmp_idx] = 1; else mca[cmp_idx] = 1;
        end
        for (int i = 0; i < N; i++)
            for (int s = 0; s < 3; s++)
                if (bc_valid && mt[i][s] == int'(bc_tag)) mr[i][s] = 1;
        if (retire_ack && e_ret >= 0) mv[e_ret] = 0;
        if (alloc_valid && !e_full) begin
            int k = e_aidx;
            mv[k] = 1; mk[k] = alloc_kind;
            mt[k][0] = alloc_tag0; mt[k][1] = alloc_tag1; mt[k][2] = alloc_tag2;
            for (int s = 0; s < 3; s++) mr[k][s] = alloc_rdy[s] || (bc_valid && mt[k][s] == int'(bc_tag));
            mda[k] = 0; mca[k] = 0;
            mdb[k] = (alloc_kind == 0); mcb[k] = (alloc_kind == 0);
            mseq[k] = seqc++;
        end
    endtask

    task automatic idle();
        flush = 0; alloc_valid = 0; alloc_kind = 0; alloc_tag0 = 0; alloc_tag1 = 0;
        alloc_tag2 = 0; alloc_rdy = 0; bc_valid = 0; bc_tag = 0;
        cmp_valid = 0; cmp_idx = 0; cmp_part = 0; retire_ack = 0;
    endtask

    // One clock: check current outputs, take the edge, advance the model.
    task automatic cycle();
        compute_exp();
        check_outputs();
        @(posedge clk);
        update_model();
        @(negedge clk);
        compute_exp();
    endtask

    task automatic alloc(input int kind, input int t0, input int t1, input int t2, input int rdy);
        alloc_valid = 1; alloc_kind = 2'(kind);
        alloc_tag0 = TW'(t0); alloc_tag1 = TW'(t1); alloc_tag2 = TW'(t2); alloc_rdy = 3'(rdy);
    endtask

    task automatic random_inputs();
        int start, pick_i, pick_p;
        idle();
        if ($urandom_range(99) < 50) begin
            int k = $urandom_range(2);
            alloc(k, $urandom_range(7), $urandom_range(7), $urandom_range(7),
                  ($urandom_range(99) < 30) ? 7 : $urandom_range(7));
        end
        if ($urandom_range(99) < 50) begin bc_valid = 1; bc_tag = TW'($urandom_range(7)); end
        start = $urandom_range(N - 1); pick_i = -1; pick_p = 0;
        for (int n = 0; n < N; n++) begin
            int i = (start + n) % N;
            if (pick_i < 0 && mv[i]) begin
                if (mda[i] && !mca[i]) begin pick_i = i; pick_p = 0; end
                else if (mdb[i] && !mcb[i] && mk[i] != 0) begin pick_i = i; pick_p = 1; end
            end
        end
        if (pick_i >= 0 && $urandom_range(99) < 60) begin
            cmp_valid = 1; cmp_idx = IW'(pick_i); cmp_part = pick_p[0];
        end
        if (e_ret >= 0 && $urandom_range(99) < 60) retire_ack = 1;
        if ($urandom_range(199) == 0) flush = 1;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        idle();
        for (int i = 0; i < N; i++) mv[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        compute_exp();
        // R1 reset state
        check("R1 full", full, 0); check("R1 alloc_idx", alloc_idx, 0);
        check("R1 agu_valid", agu_valid, 0); check("R1 sd_valid", sd_valid, 0);
        check("R1 alu_valid", alu_valid, 0); check("R1 retire_valid", retire_valid, 0);

        // R3 wakeup in the allocation cycle, R4 R5 parallel store split
        alloc(1, 5, 6, 7, 3'b110); bc_valid = 1; bc_tag = 5; cycle(); idle();
        check("R3 R4 agu after same-cycle wakeup", agu_valid, 1);
        check("R5 sd with address", sd_valid, 1);
        cycle();
        cmp_valid = 1; cmp_idx = 0; cmp_part = 1; cycle(); idle();
        check("R10 no retire with one part done", retire_valid, 0);
        cmp_valid = 1; cmp_idx = 0; cmp_part = 0; cycle(); idle();
        check("R10 retire after both parts", retire_valid, 1);
        retire_ack = 1; cycle(); idle();
        check("R11 slot freed", alloc_idx, 0);
        check("R11 no retire after ack", retire_valid, 0);

        // R5 store data ahead of its address
        alloc(1, 20, 21, 22, 3'b100); cycle(); idle();
        check("R5 sd before address", sd_valid, 1);
        check("R4 address waits for base and index", agu_valid, 0);
        cycle();

        // R6 serial load then operate
        alloc(2, 1, 2, 3, 3'b111); cycle(); idle();
        check("R6 load to agu", agu_valid, 1);
        check("R6 operate waits for load", alu_valid, 0);
        cycle();
        cmp_valid = 1; cmp_idx = IW'(1); cmp_part = 0; cycle(); idle();
        check("R6 operate after load done", alu_valid, 1);
        check("R6 operate part id", alu_part, 1);
        cycle();

        // R2 full and drop, R12 flush beats allocation
        alloc(0, 30, 31, 32, 0); cycle(); cycle(); idle();
        check("R2 full", full, 1);
        alloc(0, 33, 34, 35, 7); cycle(); idle();
        check("R2 still full after dropped alloc", full, 1);
        flush = 1; alloc(0, 36, 37, 38, 7); cycle(); idle();
        check("R12 empty after flush", full, 0);
        check("R12 flush beats alloc", alu_valid, 0);
        cycle();

        // Random churn, R7 R8 R9 covered by the model on every cycle
        for (int c = 0; c < 4000; c++) begin
            compute_exp();
            random_inputs();
            cycle();
        end
        idle(); cycle();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule